// File: doc/BRIEF.md
# Eight-Line Rotating-Priority Interrupt Controller

This block collects eight interrupt request lines into a request register and picks one of them to present to a processor. Each line is captured either on a rising edge or as a level, chosen per line by an input vector. A mask register suppresses selected lines. An in-service register records the interrupts being handled, so a lower-priority request cannot pre-empt a higher one. Priority follows a circular order whose starting point (the rotation offset) software can move.

Software programs the block through a byte-wide port with two addresses. A write to address 0 with bit 4 set begins a short sequence of initialization words, which then continue at address 1. Other address-0 writes are mode commands, which set up polling, read selection and the special-mask flag, or end-of-interrupt and rotation commands. Address-1 writes in normal operation load the mask.

The processor takes an interrupt either by pulsing the acknowledge strobe, which uses the granted level shown on `ack_level`, or by arming poll mode and reading the result at address 0. Everything is updated on one clock edge. An active-high reset is synchronous.

Top module: `prio_intc`

## Requirements
- R1: For a line with `level_sel` low (edge), the request bit is set on a clock where the input is high and was low at the previous clock edge. A low input never clears the request bit.
- R2: For a line with `level_sel` high (level), the request bit equals the input sampled at the last clock edge.
- R3: Priority scans levels rot, rot+1, ... modulo 8, and the first set bit wins. `ack_level` is the winning level among unmasked pending requests.
- R4: `int_req` is high only when the best unmasked pending level is strictly ahead, in this scan, of the best in-service level. With fully nested exception mode on, in-service bit 2 takes no part in this comparison.
- R5: An address-0 write with bit 4 set clears the request, last-level, mask and in-service registers, the rotation offset, the vector base, poll, the read select, special mask, auto-EOI, rotate-on-auto-EOI and fully nested exception mode. It records bit 0 as "fourth word follows".
- R6: After initialization starts, the next address-1 write loads `vec_base` from bits 7:3. The one after that is ignored. If the fourth word was flagged, one more address-1 write sets fully nested exception mode from bit 4 and auto-EOI from bit 1.
- R7: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. Bit 1 set loads the read select from bit 0. Bit 6 set loads `special_mask` from bit 5.
- R8: An address-0 write with bits 4 and 3 clear acts on bits 7:5. Code 0 clears rotate-on-auto-EOI and code 4 sets it. Code 1 clears the in-service bit that wins the scan. Code 5 does the same and then sets the offset to that level+1. Code 3 clears the in-service bit named by bits 2:0. Code 6 sets the offset to bits 2:0 +1. Code 7 clears the named bit and sets the offset to it+1. Code 2 has no effect.
- R9: `ack` with `int_req` high sets the in-service bit of `ack_level`, and clears its request bit only for an edge line. With auto-EOI the in-service bit ends clear, and with rotate-on-auto-EOI also set the offset becomes level+1. `ack` with `int_req` low changes nothing.
- R10: An address-1 write outside initialization loads the mask. `rdata` at address 1 is the mask. At address 0 it is the in-service register when the read select is 1, and the request register otherwise.
- R11: While poll is armed, `rdata` is the winning level when `int_req` is high and 7 otherwise. A read (`rd_en`) in that state clears that level's request and in-service bits (when `int_req` is high) and disarms poll.
- R12: Capture happens on every clock. In one cycle a write takes precedence over a read, and a read over an acknowledge. Acknowledge and poll use the state from before the edge.
- R13: Synchronous reset clears every register as R5 does. The initialization sequencer is left idle, so the next address-1 write loads the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines |
| level_sel | input | 8 | Per line: 1 = level capture, 0 = edge capture |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (consumes a poll) |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address and mode |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_req | output | 1 | Interrupt request to the processor |
| ack_level | output | 3 | Level granted by the current priority scan |
| vec_base | output | 5 | Vector base bits 7:3 from initialization |
| special_mask | output | 1 | Special-mask flag from the mode command |

## Verification
A wrong request, in-service or offset bit reaches the ports within one cycle. It changes `int_req` or `ack_level` as soon as the scan is evaluated again, and it shows in `rdata` on the next readback of that register. Bad sequencing in initialization shows up later, when a mask write lands in `vec_base` or the reverse. A reference model therefore compares every output on every clock, so an error is caught in the cycle where it first appears. The model runs through rotation, nesting and auto-EOI sequences so that offset and in-service errors cannot stay hidden.

// File: rtl/prio_intc.sv
module prio_intc (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] irq_in,
  input  logic [7:0] level_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ack,
  output logic       int_req,
  output logic [2:0] ack_level,
  output logic [4:0] vec_base,
  output logic       special_mask
);
  logic [7:0] irr, last, imr, isr;
  logic [2:0] rot;
  logic [1:0] ist;
  logic       need4, poll, rsel, sfnm, aeoi, rotaeoi;

  function automatic logic [3:0] best(input logic [7:0] m, input logic [2:0] r);
    best = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (m[3'(r + 3'(i))]) best = 4'(i);
  endfunction

  wire [7:0] pend     = irr & ~imr;
  wire [7:0] svc      = sfnm ? (isr & 8'hFB) : isr;
  wire [3:0] pend_pri = best(pend, rot);
  wire [3:0] svc_pri  = best(svc, rot);
  wire [3:0] isr_pri  = best(isr, rot);
  wire [2:0] isr_top  = isr_pri[2:0] + rot;
  wire [7:0] win_bit  = 8'b1 << ack_level;
  wire [7:0] irr_cap  = (level_sel & irq_in) | (~level_sel & (irr | (irq_in & ~last)));

  assign int_req   = pend_pri < svc_pri;
  assign ack_level = pend_pri[2:0] + rot;
  assign rdata     = poll ? (int_req ? {5'd0, ack_level} : 8'd7)
                   : addr ? imr : (rsel ? isr : irr);

  always_ff @(posedge clk) begin
    if (rst) begin
      irr <= '0; last <= '0; imr <= '0; isr <= '0; rot <= '0;
      vec_base <= '0; ist <= 2'd0; need4 <= 1'b0; poll <= 1'b0;
      rsel <= 1'b0; special_mask <= 1'b0; sfnm <= 1'b0; aeoi <= 1'b0;
      rotaeoi <= 1'b0;
    end else begin
      irr  <= irr_cap;
      last <= irq_in;
      if (wr_en) begin
        if (!addr) begin
          if (wdata[4]) begin
            irr <= '0; last <= '0; imr <= '0; isr <= '0; rot <= '0;
            vec_base <= '0; poll <= 1'b0; rsel <= 1'b0;
            special_mask <= 1'b0; sfnm <= 1'b0; aeoi <= 1'b0;
            rotaeoi <= 1'b0; ist <= 2'd1; need4 <= wdata[0];
          end else if (wdata[3]) begin
            if (wdata[2]) poll <= 1'b1;
            if (wdata[1]) rsel <= wdata[0];
            if (wdata[6]) special_mask <= wdata[5];
          end else begin
            case (wdata[7:5])
              3'd0: rotaeoi <= 1'b0;
              3'd4: rotaeoi <= 1'b1;
              3'd1, 3'd5:
                if (isr_pri != 4'd8) begin
                  isr[isr_top] <= 1'b0;
                  if (wdata[7]) rot <= isr_top + 3'd1;
                end
              3'd3: isr[wdata[2:0]] <= 1'b0;
              3'd6: rot <= wdata[2:0] + 3'd1;
              3'd7: begin
                isr[wdata[2:0]] <= 1'b0;
                rot <= wdata[2:0] + 3'd1;
              end
              default: ;
            endcase
          end
        end else begin
          case (ist)
            2'd0: imr <= wdata;
            2'd1: begin vec_base <= wdata[7:3]; ist <= 2'd2; end
            2'd2: ist <= need4 ? 2'd3 : 2'd0;
            default: begin
              sfnm <= wdata[4];
              aeoi <= wdata[1];
              ist  <= 2'd0;
            end
          endcase
        end
      end else if (rd_en) begin
        if (poll) begin
          poll <= 1'b0;
          if (int_req) begin
            irr <= irr_cap & ~win_bit;
            isr <= isr & ~win_bit;
          end
        end
      end else if (ack && int_req) begin
        isr <= aeoi ? (isr & ~win_bit) : (isr | win_bit);
        if (aeoi && rotaeoi) rot <= ack_level + 3'd1;
        if (!level_sel[ack_level]) irr <= irr_cap & ~win_bit;
      end
    end
  end

  a_r4_req_has_pending: assert property (@(posedge clk) disable iff (rst)
    int_req |-> (pend != 8'd0));
  a_r5_init_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (irr == 8'd0 && isr == 8'd0 && imr == 8'd0 && rot == 3'd0));
  a_r9_ack_sets_service: assert property (@(posedge clk) disable iff (rst)
    (ack && int_req && !wr_en && !rd_en && !aeoi) |=> isr[$past(ack_level)]);
  a_r10_mask_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && ist == 2'd0) |=> (imr == $past(wdata)));
  a_r11_poll_disarms: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && poll) |=> !poll);
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] irq_in = '0, level_sel = '0, wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] rdata;
  logic int_req, special_mask;
  logic [2:0] ack_level;
  logic [4:0] vec_base;

  always #5 clk = ~clk;

  prio_intc dut_i (.clk(clk), .rst(rst), .irq_in(irq_in), .level_sel(level_sel),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ack(ack), .int_req(int_req), .ack_level(ack_level), .vec_base(vec_base),
    .special_mask(special_mask));

  int total = 0, bad = 0;
  bit finished = 0;

  int m_irr, m_last, m_imr, m_isr, m_rot, m_vb, m_ist;
  int m_n4, m_poll, m_rsel, m_sm, m_sfnm, m_aeoi, m_rae;

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  function automatic int scan(int m);
    for (int i = 0; i < 8; i++)
      if (bitof(m, (m_rot + i) % 8)) return i;
    return 8;
  endfunction

  function automatic int m_req();
    int c = m_sfnm ? (m_isr & 'hFB) : m_isr;
    return (scan(m_irr & ~m_imr & 'hFF) < scan(c)) ? 1 : 0;
  endfunction

  function automatic int m_lvl();
    return (scan(m_irr & ~m_imr & 'hFF) + m_rot) % 8;
  endfunction

  function automatic int m_rdata();
    if (m_poll) return m_req() ? m_lvl() : 7;
    if (addr) return m_imr;
    return m_rsel ? m_isr : m_irr;
  endfunction

  task automatic m_clear();
    m_irr = 0; m_last = 0; m_imr = 0; m_isr = 0; m_rot = 0; m_vb = 0;
    m_poll = 0; m_rsel = 0; m_sm = 0; m_sfnm = 0; m_aeoi = 0; m_rae = 0;
  endtask

  task automatic m_step();
    int cap = 0;
    int req = m_req();
    int lv = m_lvl();
    int d = wdata;
    int p;
    if (rst) begin m_clear(); m_ist = 0; m_n4 = 0; return; end
    for (int b = 0; b < 8; b++) begin
      int inb = irq_in[b];
      int nb;
      if (level_sel[b]) nb = inb;
      else nb = bitof(m_irr, b) | (inb & ~bitof(m_last, b) & 1);
      cap |= nb << b;
    end
    m_last = irq_in;
    if (wr_en) begin
      m_irr = cap;
      if (!addr) begin
        if (bitof(d, 4)) begin m_clear(); m_ist = 1; m_n4 = bitof(d, 0); end
        else if (bitof(d, 3)) begin
          if (bitof(d, 2)) m_poll = 1;
          if (bitof(d, 1)) m_rsel = bitof(d, 0);
          if (bitof(d, 6)) m_sm = bitof(d, 5);
        end else begin
          case (d >> 5)
            0: m_rae = 0;
            4: m_rae = 1;
            1, 5: begin
              p = scan(m_isr);
              if (p != 8) begin
                p = (p + m_rot) % 8;
                m_isr &= ~(1 << p);
                if ((d >> 5) == 5) m_rot = (p + 1) % 8;
              end
            end
            3: m_isr &= ~(1 << (d & 7));
            6: m_rot = ((d & 7) + 1) % 8;
            7: begin m_isr &= ~(1 << (d & 7)); m_rot = ((d & 7) + 1) % 8; end
            default: ;
          endcase
        end
      end else begin
        if (m_ist == 0) m_imr = d;
        else if (m_ist == 1) begin m_vb = d >> 3; m_ist = 2; end
        else if (m_ist == 2) m_ist = m_n4 ? 3 : 0;
        else begin m_sfnm = bitof(d, 4); m_aeoi = bitof(d, 1); m_ist = 0; end
      end
    end else if (rd_en && m_poll) begin
      m_poll = 0;
      m_irr = cap;
      if (req) begin m_irr &= ~(1 << lv); m_isr &= ~(1 << lv); end
    end else if (ack && !rd_en && req) begin
      m_irr = cap;
      if (m_aeoi) begin
        m_isr &= ~(1 << lv);
        if (m_rae) m_rot = (lv + 1) % 8;
      end else m_isr |= 1 << lv;
      if (!level_sel[lv]) m_irr &= ~(1 << lv);
    end else m_irr = cap;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    #1;
    chk(tag, "int_req", int_req, m_req());
    if (m_req()) chk(tag, "ack_level", ack_level, m_lvl());
    chk(tag, "rdata", rdata, m_rdata());
    chk(tag, "vec_base", vec_base, m_vb);
    chk(tag, "special_mask", special_mask, m_sm);
    @(posedge clk);
    m_step();
    @(negedge clk);
    wr_en = 0; rd_en = 0; ack = 0;
  endtask

  task automatic wr(bit a, int d, string tag);
    wr_en = 1; addr = a; wdata = 8'(d); tick(tag);
  endtask
  task automatic rd(bit a, string tag);
    rd_en = 1; addr = a; tick(tag);
  endtask
  task automatic do_ack(string tag);
    ack = 1; tick(tag);
  endtask
  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    m_clear(); m_ist = 0; m_n4 = 0;
    @(negedge clk); @(negedge clk);
    rst = 1; idle(2, "R13");
    rst = 0; idle(1, "R13");
    // R13: sequencer idle, address-1 write loads mask
    wr(1, 'h5A, "R13"); addr = 1; idle(1, "R13");
    chk("R13", "mask after reset", rdata, 'h5A);
    // R5/R6 init with fourth word
    wr(0, 'h11, "R5"); addr = 1; idle(1, "R5");
    chk("R5", "mask cleared", rdata, 0);
    wr(1, 'h47, "R6"); wr(1, 'hFF, "R6"); wr(1, 'h00, "R6");
    chk("R6", "vec_base", vec_base, 8);
    // R10 mask + R1 edge capture
    wr(1, 'hF0, "R10"); addr = 1; idle(1, "R10");
    irq_in = 'h08; addr = 0; idle(2, "R1");
    chk("R1", "edge request", int_req, 1);
    irq_in = 'h00; idle(2, "R1");
    chk("R1", "low keeps request", rdata, 'h08);
    do_ack("R9"); idle(1, "R9");
    wr(0, 'h0B, "R10"); idle(1, "R10");
    chk("R10", "isr read", rdata, 'h08);
    wr(0, 'h0A, "R10");
    wr(0, 'h20, "R8"); idle(1, "R8");
    // R2 level line 5 (unmasked)
    wr(1, 'h00, "R10");
    level_sel = 'h20; irq_in = 'h20; idle(2, "R2");
    irq_in = 'h00; idle(2, "R2");
    chk("R2", "level drop", int_req, 0);
    // R4 nesting: lines 1 and 3
    level_sel = 'h00; irq_in = 'h0A; idle(1, "R4");
    do_ack("R4"); idle(2, "R4");
    do_ack("R4"); idle(1, "R4");
    wr(0, 'h60 | 1, "R8"); idle(1, "R4");
    do_ack("R9"); wr(0, 'h20, "R8");
    irq_in = 0; idle(1, "R3");
    // R3 rotation: offset 3 via code 6 (bits 2:0 = 2)
    wr(0, 'hC2, "R8");
    irq_in = 'h12; idle(2, "R3");
    chk("R3", "rotated winner", ack_level, 4);
    do_ack("R3"); wr(0, 'hA0, "R8"); idle(1, "R8");
    do_ack("R3"); wr(0, 'hE1, "R8"); wr(0, 'h40, "R8");
    irq_in = 0;
    // R7 special mask, poll R11
    wr(0, 'h68, "R7"); wr(0, 'h48, "R7");
    irq_in = 'h04; idle(1, "R11");
    wr(0, 'h0C, "R7"); addr = 0; idle(1, "R11");
    rd(0, "R11"); idle(1, "R11");
    wr(0, 'h0C, "R11"); rd(0, "R11");
    chk("R11", "poll disarmed", rdata, 0);
    // R12 write wins over ack
    irq_in = 'h00; idle(1, "R12"); irq_in = 'h01; idle(1, "R12");
    ack = 1; wr(1, 'h00, "R12"); idle(1, "R12");
    do_ack("R12"); wr(0, 'h20, "R12");
    // auto-EOI with rotate, fully nested exception
    wr(0, 'h13, "R6"); wr(1, 'h08, "R6"); wr(1, 0, "R6"); wr(1, 'h12, "R6");
    wr(0, 'h80, "R8");
    irq_in = 0; idle(1, "R9"); irq_in = 'h84; idle(1, "R9");
    do_ack("R9"); idle(1, "R9"); do_ack("R9"); idle(1, "R9");
    wr(0, 'h00, "R8"); do_ack("R9");
    // R4 fully nested exception without auto-EOI
    wr(0, 'h11, "R5"); wr(1, 0, "R6"); wr(1, 0, "R6"); wr(1, 'h10, "R6");
    irq_in = 0; idle(1, "R4"); irq_in = 'h04; idle(1, "R4");
    do_ack("R4"); irq_in = 0; idle(1, "R4"); irq_in = 'h04; idle(2, "R4");
    chk("R4", "nested exception re-request", int_req, 1);
    do_ack("R9"); idle(1, "R9");
    rst = 1; idle(1, "R13"); rst = 0; idle(2, "R13");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule